// File: doc/BRIEF.md
# Threshold-Flagged Ring Pointer Controller

This block keeps the bookkeeping for a circular buffer whose storage sits in external memory. It holds a write pointer, a read pointer and an occupancy level for a window of `2**DEPTH_LOG2` entries that begins at a base address given on an input. Every cycle it takes one write strobe and one read strobe. It reports both pointers, the memory address each pointer selects, and the level. It also produces two flags, `can_push` and `can_pop`.

The flags are not plain full and empty indications. Each one compares the level against its own threshold, and both thresholds come in on ports. A producer can therefore be told to stop before the window is physically full. A consumer can be held off until a minimum amount of data has built up. The block moves no data and issues no memory requests itself.

Internally, an occupancy state machine has three states: `OCC_EMPTY`, `OCC_PARTIAL` and `OCC_FULL`. It moves between them as follows:

- `OCC_EMPTY` to `OCC_PARTIAL`: a write is accepted with no read.
- `OCC_PARTIAL` to `OCC_FULL`: a write-only cycle is accepted at level DEPTH-1.
- `OCC_PARTIAL` to `OCC_EMPTY`: a read-only cycle is accepted at level 1.
- `OCC_FULL` to `OCC_PARTIAL`: a read-only cycle is accepted.

Any other combination holds the current state. This state gates the hard limits of the window, and the threshold flags sit on top of it.

Top module: `ring_ptr_ctrl`

## Requirements
- R1: After reset, both pointers and the level read 0.
- R2: Each accepted write advances `wr_ptr` by one, modulo DEPTH. The new value appears after the clock edge that samples the strobe.
- R3: Each accepted read advances `rd_ptr` by one, modulo DEPTH.
- R4: The level goes up by one on a cycle with only an accepted write. It goes down by one on a cycle with only an accepted read. It is unchanged when both are accepted together or when neither is.
- R5: `can_push` is combinationally 1 exactly when level < `push_limit`.
- R6: `can_pop` is combinationally 1 exactly when level > `pop_limit`.
- R7: With `pop_limit` = 0 and `push_limit` = DEPTH, the flags act as not-empty and not-full.
- R8: `wr_addr` equals `base_addr + wr_ptr`, and `rd_addr` equals `base_addr + rd_ptr`, both modulo 2**ADDR_W.
- R9: A write strobe is ignored (neither pointer nor level moves for it) when `can_push` is 0 or the level is DEPTH. The level never exceeds DEPTH.
- R10: A read strobe is ignored when `can_pop` is 0 or the level is 0.
- R11: When both strobes are high and only one of them is accepted, only the accepted one acts on the pointers and the level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_req | input | 1 | Write strobe, one entry per cycle |
| pop_req | input | 1 | Read strobe, one entry per cycle |
| base_addr | input | ADDR_W | First memory address of the window |
| push_limit | input | DEPTH_LOG2+1 | Write threshold |
| pop_limit | input | DEPTH_LOG2+1 | Read threshold |
| wr_ptr | output | DEPTH_LOG2 | Write offset in the window |
| rd_ptr | output | DEPTH_LOG2 | Read offset in the window |
| wr_addr | output | ADDR_W | Memory address of the next write |
| rd_addr | output | ADDR_W | Memory address of the next read |
| level | output | DEPTH_LOG2+1 | Entries held |
| can_push | output | 1 | Level below write threshold |
| can_pop | output | 1 | Level above read threshold |

## Verification
The bench runs each input pattern for a specific reason:

- Long write-only bursts past full, followed by long read-only bursts past empty, use the default thresholds. They separate correct wrap of the pointers from saturation, and they show that refused strobes leave the state untouched.
- Simultaneous strobes at empty, at full and in the middle. These tell a balanced update apart from the one-sided update that happens when only one strobe is accepted.
- Random strobes under randomly chosen thresholds, including write thresholds above DEPTH and read thresholds near DEPTH. These separate the threshold compare from the physical full and empty limits.
- A base address close to the top of the address space. This shows that the address sums wrap rather than saturate.

// File: rtl/rpc_pkg.sv
package rpc_pkg;

    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_e;

endpackage

// File: rtl/rpc_ring_ptr.sv
module rpc_ring_ptr #(
    parameter int PTR_W  = 4,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic [ADDR_W-1:0] base,
    output logic [PTR_W-1:0]  ptr,
    output logic [ADDR_W-1:0] addr
);

    localparam int PAD_W = ADDR_W - PTR_W;

    logic [PTR_W-1:0] ptr_q;

    // Power-of-two window: natural wrap of the counter is the modulo
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (advance) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    assign ptr  = ptr_q;
    assign addr = base + {{PAD_W{1'b0}}, ptr_q};

endmodule

// File: rtl/rpc_occupancy.sv
module rpc_occupancy
    import rpc_pkg::*;
#(
    parameter int DEPTH_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              dec,
    output logic [DEPTH_LOG2:0] level,
    output logic              is_empty,
    output logic              is_full
);

    localparam int LVL_W = DEPTH_LOG2 + 1;
    localparam logic [LVL_W-1:0] DEPTH_V = LVL_W'(1) << DEPTH_LOG2;
    localparam logic [LVL_W-1:0] NEAR_FULL = DEPTH_V - 1'b1;
    localparam logic [LVL_W-1:0] ONE_V = LVL_W'(1);

    occ_state_e       state_q, state_d;
    logic [LVL_W-1:0] level_q;
    logic             up_only, down_only;

    assign up_only   = inc && !dec;
    assign down_only = dec && !inc;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OCC_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OCC_EMPTY: begin
                if (up_only) state_d = OCC_PARTIAL;
            end
            OCC_PARTIAL: begin
                if (up_only && level_q == NEAR_FULL) begin
                    state_d = OCC_FULL;
                end else if (down_only && level_q == ONE_V) begin
                    state_d = OCC_EMPTY;
                end
            end
            OCC_FULL: begin
                if (down_only) state_d = OCC_PARTIAL;
            end
            default: state_d = OCC_EMPTY;
        endcase
    end

    // Level counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
        end else if (up_only) begin
            level_q <= level_q + 1'b1;
        end else if (down_only) begin
            level_q <= level_q - 1'b1;
        end
    end

    // Outputs
    always_comb begin
        is_empty = 1'b0;
        is_full  = 1'b0;
        unique case (state_q)
            OCC_EMPTY:   is_empty = 1'b1;
            OCC_PARTIAL: ;
            OCC_FULL:    is_full  = 1'b1;
            default:     is_empty = 1'b1;
        endcase
    end

    assign level = level_q;

endmodule

// File: rtl/rpc_flag_cmp.sv
module rpc_flag_cmp #(
    parameter int LVL_W = 5
) (
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] push_limit,
    input  logic [LVL_W-1:0] pop_limit,
    output logic             can_push,
    output logic             can_pop
);

    assign can_push = level < push_limit;
    assign can_pop  = level > pop_limit;

endmodule

// File: rtl/ring_ptr_ctrl.sv
module ring_ptr_ctrl #(
    parameter int DEPTH_LOG2 = 4,
    parameter int ADDR_W     = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  push_req,
    input  logic                  pop_req,
    input  logic [ADDR_W-1:0]     base_addr,
    input  logic [DEPTH_LOG2:0]   push_limit,
    input  logic [DEPTH_LOG2:0]   pop_limit,
    output logic [DEPTH_LOG2-1:0] wr_ptr,
    output logic [DEPTH_LOG2-1:0] rd_ptr,
    output logic [ADDR_W-1:0]     wr_addr,
    output logic [ADDR_W-1:0]     rd_addr,
    output logic [DEPTH_LOG2:0]   level,
    output logic                  can_push,
    output logic                  can_pop
);

    localparam int LVL_W = DEPTH_LOG2 + 1;

    logic occ_empty, occ_full;
    logic push_take, pop_take;

    // Thresholds gate first; physical limits guard against odd thresholds
    assign push_take = push_req && can_push && !occ_full;
    assign pop_take  = pop_req  && can_pop  && !occ_empty;

    rpc_ring_ptr #(.PTR_W(DEPTH_LOG2), .ADDR_W(ADDR_W)) u_wr_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (push_take),
        .base    (base_addr),
        .ptr     (wr_ptr),
        .addr    (wr_addr)
    );

    rpc_ring_ptr #(.PTR_W(DEPTH_LOG2), .ADDR_W(ADDR_W)) u_rd_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (pop_take),
        .base    (base_addr),
        .ptr     (rd_ptr),
        .addr    (rd_addr)
    );

    rpc_occupancy #(.DEPTH_LOG2(DEPTH_LOG2)) u_occ (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (push_take),
        .dec      (pop_take),
        .level    (level),
        .is_empty (occ_empty),
        .is_full  (occ_full)
    );

    rpc_flag_cmp #(.LVL_W(LVL_W)) u_flags (
        .level      (level),
        .push_limit (push_limit),
        .pop_limit  (pop_limit),
        .can_push   (can_push),
        .can_pop    (can_pop)
    );

endmodule

// File: rtl/ring_ptr_ctrl_chk.sv
module ring_ptr_ctrl_chk #(
    parameter int DEPTH_LOG2 = 4,
    parameter int ADDR_W     = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  push_req,
    input logic                  pop_req,
    input logic [DEPTH_LOG2-1:0] wr_ptr,
    input logic [DEPTH_LOG2-1:0] rd_ptr,
    input logic [DEPTH_LOG2:0]   level,
    input logic                  can_push,
    input logic                  can_pop
);

    localparam int LVL_W = DEPTH_LOG2 + 1;
    localparam logic [LVL_W-1:0] DEPTH_V = LVL_W'(1) << DEPTH_LOG2;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (level == '0 && wr_ptr == '0 && rd_ptr == '0)); // R1

    AST_WPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && can_push && level != DEPTH_V)
        |=> wr_ptr == $past(wr_ptr) + 1'b1); // R2

    AST_RPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && can_pop && level != '0)
        |=> rd_ptr == $past(rd_ptr) + 1'b1); // R3

    AST_LEVEL_MATCHES_PTRS: assert property (@(posedge clk) disable iff (!rst_n)
        level[DEPTH_LOG2-1:0] == DEPTH_LOG2'(wr_ptr - rd_ptr)); // R4

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        level <= DEPTH_V); // R9

    AST_BLOCKED_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !can_push) |=> $stable(wr_ptr)); // R9

    AST_BLOCKED_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !can_pop) |=> $stable(rd_ptr)); // R10

endmodule

bind ring_ptr_ctrl ring_ptr_ctrl_chk #(
    .DEPTH_LOG2 (DEPTH_LOG2),
    .ADDR_W     (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_req (push_req),
    .pop_req  (pop_req),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr),
    .level    (level),
    .can_push (can_push),
    .can_pop  (can_pop)
);

// File: tb/ring_ptr_ctrl_test.sv
`timescale 1ns/1ps
module ring_ptr_ctrl_test;

    localparam int DL = 4;
    localparam int AW = 32;
    localparam int DEPTH = 1 << DL;
    localparam int LW = DL + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_req = 1'b0, pop_req = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [LW-1:0] push_limit = LW'(DEPTH), pop_limit = '0;
    logic [DL-1:0] wr_ptr, rd_ptr;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [LW-1:0] level;
    logic          can_push, can_pop;

    int n_checks = 0, n_fail = 0;
    int m_level = 0, m_wp = 0, m_rp = 0;

    always #5 clk = ~clk;

    ring_ptr_ctrl #(.DEPTH_LOG2(DL), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(pop_req),
        .base_addr(base_addr), .push_limit(push_limit), .pop_limit(pop_limit),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .wr_addr(wr_addr), .rd_addr(rd_addr),
        .level(level), .can_push(can_push), .can_pop(can_pop)
    );

    function automatic bit exp_push_ok(int lvl, int lim);
        return (lvl < lim) && (lvl < DEPTH);
    endfunction

    function automatic bit exp_pop_ok(int lvl, int lim);
        return (lvl > lim) && (lvl > 0);
    endfunction

    function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] b, int p);
        return b + AW'(p);
    endfunction

    task automatic chk(bit ok, string tag, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_all();
        chk(wr_ptr == DL'(m_wp), "R2 wr_ptr", wr_ptr, m_wp);
        chk(rd_ptr == DL'(m_rp), "R3 rd_ptr", rd_ptr, m_rp);
        chk(level == LW'(m_level), "R4 level", level, m_level);
        chk(can_push == (m_level < int'(push_limit)), "R5 can_push", can_push, m_level < int'(push_limit));
        chk(can_pop == (m_level > int'(pop_limit)), "R6 can_pop", can_pop, m_level > int'(pop_limit));
        chk(wr_addr == exp_addr(base_addr, m_wp), "R8 wr_addr", wr_addr, exp_addr(base_addr, m_wp));
        chk(rd_addr == exp_addr(base_addr, m_rp), "R8 rd_addr", rd_addr, exp_addr(base_addr, m_rp));
    endtask

    // Called at a negedge: drive, clock, update model, check at next negedge
    task automatic cycle(bit w, bit r);
        bit wo, ro;
        push_req = w;
        pop_req  = r;
        wo = w && exp_push_ok(m_level, int'(push_limit));
        ro = r && exp_pop_ok(m_level, int'(pop_limit));
        @(posedge clk);
        if (wo) m_wp = (m_wp + 1) % DEPTH;
        if (ro) m_rp = (m_rp + 1) % DEPTH;
        m_level = m_level + int'(wo) - int'(ro);
        @(negedge clk);
        push_req = 1'b0;
        pop_req  = 1'b0;
        check_all();
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int lvl_hold, wp_hold;
        void'($urandom(32'd2024));
        base_addr = 32'hFFFF_FFF8;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(level == 0 && wr_ptr == 0 && rd_ptr == 0, "R1 reset", level, 0);
        check_all();

        // R7 default thresholds: fill past full (R2 wrap, R9 saturation)
        for (int i = 0; i < DEPTH + 4; i++) cycle(1'b1, 1'b0);
        chk(level == LW'(DEPTH), "R9 full level", level, DEPTH);
        chk(can_push == 1'b0, "R7 not-full flag at full", can_push, 0);
        chk(can_pop == 1'b1, "R7 not-empty flag at full", can_pop, 1);
        // R11 both strobes at full: only read acts
        cycle(1'b1, 1'b1);
        chk(level == LW'(DEPTH - 1), "R11 both at full", level, DEPTH - 1);
        cycle(1'b1, 1'b1);
        chk(level == LW'(DEPTH - 1), "R4 both mid", level, DEPTH - 1);
        // drain past empty (R3 wrap, R10 ignored)
        for (int i = 0; i < DEPTH + 4; i++) cycle(1'b0, 1'b1);
        chk(level == 0, "R10 empty level", level, 0);
        chk(can_pop == 1'b0, "R7 not-empty flag at empty", can_pop, 0);
        // R11 both at empty: only write acts
        wp_hold = m_wp;
        cycle(1'b1, 1'b1);
        chk(level == 1 && wr_ptr == DL'(wp_hold + 1), "R11 both at empty", level, 1);

        // R9 blocked by threshold below full
        push_limit = 5'd1;
        @(negedge clk);
        lvl_hold = m_level;
        cycle(1'b1, 1'b0);
        chk(level == LW'(lvl_hold), "R9 push blocked by limit", level, lvl_hold);
        // R10 blocked by read threshold
        pop_limit = 5'd3;
        @(negedge clk);
        cycle(1'b0, 1'b1);
        chk(level == LW'(lvl_hold), "R10 pop blocked by limit", level, lvl_hold);

        // Random phase under random thresholds
        base_addr = $urandom;
        for (int blk = 0; blk < 60; blk++) begin
            push_limit = LW'($urandom_range(0, DEPTH + 4));
            pop_limit  = LW'($urandom_range(0, DEPTH));
            if (blk % 4 == 0) begin
                push_limit = LW'(DEPTH);
                pop_limit  = '0;
            end
            @(negedge clk);
            check_all();
            for (int i = 0; i < 64; i++) begin
                cycle(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule